// File: doc/BRIEF.md
# Bridge Interrupt Status and Write-Lock Register Block

This block sits in the control path of a host-to-PCI bridge. It gathers eight single-cycle event pulses from the local side into a latched status byte. It masks that byte with a programmable byte of the same layout and drives one interrupt line. The line is active only when a local-interrupt enable bit in a bus configuration register is set.

The block also keeps the sticky bits of a 16-bit PCI error status word. These bits are set by error pulses and cleared by writing ones. It also holds a system control register, which drives the PCI bus reset output. A lock bit protects that register, and only a 16-bit key value releases the lock.

Software reaches the block through a plain register port: a write strobe, an address, write data and a read-data bus that is registered once. The two status registers use opposite clearing rules, and the driver must respect that: the event byte clears bits that are written as zero, and the error word clears bits that are written as one.

Top module: `bridge_irq_regs`

## Requirements
- R1: Pulse input `lcl_evt[i]` sets status bit i, which stays set until cleared. The bit layout is: 7 mailbox, 6 PCI read abort, 5 PCI write abort, 4 PCI pin interrupt, 3 PCI parity error, 2 inbound post-queue write, 1 DMA channel 1, 0 DMA channel 0.
- R2: A write to the status byte (address 0) clears each status bit whose write-data bit is 0 and leaves each bit whose write-data bit is 1. Writing 0x00 clears all eight bits.
- R3: When an event pulse and a clearing write to the same register land in the same cycle, the event wins and its bit reads as set. This holds for both the status byte and the error word.
- R4: The mask byte (address 1) uses the status bit layout. `irq_out` is high in the cycle after (status AND mask) is non-zero while bit 10 of the configuration register (address 4) is 1.
- R5: While configuration bit 10 is 0, `irq_out` stays low whatever the status and mask hold.
- R6: The error word (address 2) has four sticky bits: 15 parity error, 14 system error, 13 master abort, 12 target abort. They are set by `pci_err_evt[3:0]` in that order, from bit 15 down to bit 12. Writing a 1 to one of these bits clears it, and writing a 0 has no effect. Bits 11..0 always read 0.
- R7: While unlocked, a write to the system register (address 3) stores all 16 bits. Bit 15 drives `pci_rst_n`, and a 0 in that bit holds the PCI bus in reset.
- R8: While system bit 14 (lock) is 1, every write to the system register other than 0xA05F is ignored.
- R9: Writing 0xA05F while locked clears only the lock bit and keeps every other system bit.
- R10: After reset, every register reads 0: status, mask, error word, system register and configuration. `irq_out` is low and `pci_rst_n` is low.
- R11: `reg_rdata` shows the register selected by `reg_addr` one clock later. Addresses 5 to 7 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address for read and write |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| lcl_evt | input | 8 | Local event pulses, one per status bit |
| pci_err_evt | input | 4 | PCI error pulses, in order parity, system, master abort, target abort |
| irq_out | output | 1 | Registered interrupt request |
| pci_rst_n | output | 1 | PCI bus reset, active low |

## Verification
Two pairs of functions can fall in the same cycle: an event pulse and a clearing write to the status byte, and an error pulse and a write-one-to-clear to the error word. Directed steps assert both at one clock edge. The bench then reads the register back and requires the pulsed bit to be set while all other bits are cleared. Random steps also mix event pulses with register writes of random data, and every readback is compared with a bench model that gives the event priority.

// File: rtl/bridge_irq_pkg.sv
package bridge_irq_pkg;
  localparam int EVT_W        = 8;
  localparam int DATA_W       = 16;
  localparam int ADDR_W       = 3;
  localparam int ERR_W        = 4;
  localparam int ERR_LSB      = DATA_W - ERR_W;
  localparam int SYS_RST_BIT  = 15;
  localparam int SYS_LOCK_BIT = 14;
  localparam int CFG_IEN_BIT  = 10;
  localparam logic [DATA_W-1:0] SYS_KEY = 16'hA05F;

  typedef enum logic [ADDR_W-1:0] {
    RA_STAT = 3'd0,
    RA_MASK = 3'd1,
    RA_ERR  = 3'd2,
    RA_SYS  = 3'd3,
    RA_CFG  = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/evt_status.sv
module evt_status #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_wr,
  input  logic [W-1:0] clr_data,
  input  logic [W-1:0] evt,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                           stat_q[i] <= 1'b0;
      else if (evt[i])                   stat_q[i] <= 1'b1;
      else if (clr_wr && !clr_data[i])   stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R3
  evt_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (|evt) |=> ((stat_q & $past(evt)) == $past(evt)));
  // R2
  zero_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_wr && clr_data == '0 && evt == '0) |=> (stat_q == '0));
endmodule

// File: rtl/err_status.sv
module err_status #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         w1c_wr,
  input  logic [W-1:0] w1c_data,
  input  logic [W-1:0] evt,
  output logic [W-1:0] err_o
);
  logic [W-1:0] err_q;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)                        err_q[i] <= 1'b0;
      else if (evt[i])                err_q[i] <= 1'b1;
      else if (w1c_wr && w1c_data[i]) err_q[i] <= 1'b0;
    end
  end

  assign err_o = err_q;

  // R6
  ones_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (w1c_wr && w1c_data == '1 && evt == '0) |=> (err_q == '0));
  // R6
  zero_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    (w1c_wr && w1c_data == '0) |=> ((err_q & $past(err_q)) == $past(err_q)));
endmodule

// File: rtl/sys_lock.sv
module sys_lock #(
  parameter int              DW       = 16,
  parameter int              LOCK_BIT = 14,
  parameter logic [DW-1:0]   KEY      = 16'hA05F
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] sys_o
);
  logic [DW-1:0] sys_q;
  logic          locked;
  logic          key_hit;

  assign locked  = sys_q[LOCK_BIT];
  assign key_hit = (wdata == KEY);

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_q <= '0;
    end else if (wr) begin
      if (!locked)      sys_q           <= wdata;
      else if (key_hit) sys_q[LOCK_BIT] <= 1'b0;
    end
  end

  assign sys_o = sys_q;

  // R8
  locked_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && wr && !key_hit) |=> $stable(sys_q));
  // R9
  key_unlock_chk: assert property (@(posedge clk) disable iff (rst)
    (locked && wr && key_hit) |=> (!sys_q[LOCK_BIT] &&
      ((sys_q | (DW'(1) << LOCK_BIT)) == $past(sys_q))));
endmodule

// File: rtl/bridge_irq_regs.sv
module bridge_irq_regs
  import bridge_irq_pkg::*;
#(
  parameter int EW  = EVT_W,
  parameter int DW  = DATA_W,
  parameter int AW  = ADDR_W,
  parameter int XW  = ERR_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic [EW-1:0] lcl_evt,
  input  logic [XW-1:0] pci_err_evt,
  output logic          irq_out,
  output logic          pci_rst_n
);
  localparam int XLSB = DW - XW;

  logic [EW-1:0] stat_w;
  logic [EW-1:0] mask_q;
  logic [XW-1:0] err_w;
  logic [DW-1:0] sys_w;
  logic [DW-1:0] cfg_q;
  logic [DW-1:0] rdata_q;
  logic          irq_q;
  logic          wr_stat, wr_mask, wr_err, wr_sys, wr_cfg;
  logic          ien;

  assign wr_stat = reg_wr && (reg_addr == RA_STAT);
  assign wr_mask = reg_wr && (reg_addr == RA_MASK);
  assign wr_err  = reg_wr && (reg_addr == RA_ERR);
  assign wr_sys  = reg_wr && (reg_addr == RA_SYS);
  assign wr_cfg  = reg_wr && (reg_addr == RA_CFG);
  assign ien     = cfg_q[CFG_IEN_BIT];

  evt_status #(.W(EW)) u_stat (
    .clk(clk), .rst(rst), .clr_wr(wr_stat), .clr_data(reg_wdata[EW-1:0]),
    .evt(lcl_evt), .stat_o(stat_w));

  err_status #(.W(XW)) u_err (
    .clk(clk), .rst(rst), .w1c_wr(wr_err), .w1c_data(reg_wdata[DW-1:XLSB]),
    .evt(pci_err_evt), .err_o(err_w));

  sys_lock #(.DW(DW), .LOCK_BIT(SYS_LOCK_BIT), .KEY(SYS_KEY)) u_sys (
    .clk(clk), .rst(rst), .wr(wr_sys), .wdata(reg_wdata), .sys_o(sys_w));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_mask) mask_q <= reg_wdata[EW-1:0];
      if (wr_cfg)  cfg_q  <= reg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= ien && ((stat_w & mask_q) != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (reg_addr)
        RA_STAT: rdata_q <= DW'(stat_w);
        RA_MASK: rdata_q <= DW'(mask_q);
        RA_ERR:  rdata_q <= {err_w, {XLSB{1'b0}}};
        RA_SYS:  rdata_q <= sys_w;
        RA_CFG:  rdata_q <= cfg_q;
        default: rdata_q <= '0;
      endcase
    end
  end

  assign reg_rdata = rdata_q;
  assign irq_out   = irq_q;
  assign pci_rst_n = sys_w[SYS_RST_BIT];

  // R5
  ien_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !ien |=> !irq_q);
  // R4
  irq_needs_mask_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(mask_q != '0));
  // R4
  irq_needs_stat_chk: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> $past(stat_w != '0));
endmodule

// File: tb/sim_bridge_irq_regs.sv
module sim_bridge_irq_regs;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [15:0] reg_wdata;
  logic [15:0] reg_rdata;
  logic [7:0]  lcl_evt;
  logic [3:0]  pci_err_evt;
  logic        irq_out;
  logic        pci_rst_n;

  int tests = 0;
  int fails = 0;

  logic [7:0]  m_stat, m_mask;
  logic [3:0]  m_err;
  logic [15:0] m_sys, m_cfg;

  always #5 clk = ~clk;

  bridge_irq_regs u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lcl_evt(lcl_evt),
    .pci_err_evt(pci_err_evt), .irq_out(irq_out), .pci_rst_n(pci_rst_n));

  function automatic logic [15:0] model_rd(input logic [2:0] a);
    case (a)
      3'd0: return {8'h00, m_stat};
      3'd1: return {8'h00, m_mask};
      3'd2: return {m_err, 12'h000};
      3'd3: return m_sys;
      3'd4: return m_cfg;
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic model_irq();
    return m_cfg[10] && ((m_stat & m_mask) != 8'h00);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [2:0] a, input logic [15:0] d,
                      input logic [7:0] e, input logic [3:0] x);
    @(negedge clk);
    reg_wr = wr; reg_addr = a; reg_wdata = d; lcl_evt = e; pci_err_evt = x;
    @(negedge clk);
    reg_wr = 1'b0; lcl_evt = '0; pci_err_evt = '0;
    m_stat = (m_stat & ((wr && a == 3'd0) ? d[7:0] : 8'hFF)) | e;
    m_err  = (m_err & ~((wr && a == 3'd2) ? d[15:12] : 4'h0)) | x;
    if (wr && a == 3'd1) m_mask = d[7:0];
    if (wr && a == 3'd4) m_cfg = d;
    if (wr && a == 3'd3) begin
      if (!m_sys[14])          m_sys = d;
      else if (d == 16'hA05F)  m_sys[14] = 1'b0;
    end
  endtask

  task automatic rd_check(input string req, input logic [2:0] a);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    check(req, reg_rdata, model_rd(a));
  endtask

  task automatic out_check(input string req);
    check({req, " irq"}, {15'd0, irq_out}, {15'd0, model_irq()});
    check({req, " pci_rst_n"}, {15'd0, pci_rst_n}, {15'd0, m_sys[15]});
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; lcl_evt = 0; pci_err_evt = 0;
    m_stat = 0; m_mask = 0; m_err = 0; m_sys = 0; m_cfg = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state, R11 unmapped addresses read zero
    for (int a = 0; a < 8; a++) rd_check(a > 4 ? "R11" : "R10", 3'(a));
    out_check("R10");

    // R1 each event bit alone, then R2 clear by writing zero
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 3'd0, 16'h0, 8'(1 << i), 4'h0);
      rd_check("R1", 3'd0);
      step(1'b1, 3'd0, 16'h0000, 8'h00, 4'h0);
      rd_check("R2", 3'd0);
    end

    // R2 partial clear keeps bits written as one
    step(1'b0, 3'd0, 16'h0, 8'hFF, 4'h0);
    step(1'b1, 3'd0, 16'h000F, 8'h00, 4'h0);
    rd_check("R2", 3'd0);

    // R3 event and clearing write in one cycle
    step(1'b1, 3'd0, 16'h0000, 8'h80, 4'h0);
    rd_check("R3", 3'd0);

    // R4 masked interrupt with enable set
    step(1'b1, 3'd1, 16'h0004, 8'h00, 4'h0);
    step(1'b1, 3'd4, 16'h0400, 8'h00, 4'h0);
    rd_check("R4", 3'd1);
    out_check("R4");
    step(1'b0, 3'd0, 16'h0, 8'h04, 4'h0);
    rd_check("R4", 3'd0);
    out_check("R4");
    // R5 enable off forces the line low
    step(1'b1, 3'd4, 16'h0000, 8'h00, 4'h0);
    rd_check("R5", 3'd4);
    out_check("R5");
    step(1'b1, 3'd0, 16'h0000, 8'h00, 4'h0);

    // R6 error word: set, write-zero no effect, write-one clears, R3 collision
    step(1'b0, 3'd0, 16'h0, 8'h00, 4'hF);
    rd_check("R6", 3'd2);
    step(1'b1, 3'd2, 16'h0FFF, 8'h00, 4'h0);
    rd_check("R6", 3'd2);
    step(1'b1, 3'd2, 16'h5000, 8'h00, 4'h0);
    rd_check("R6", 3'd2);
    step(1'b1, 3'd2, 16'hF000, 8'h00, 4'h2);
    rd_check("R3", 3'd2);
    step(1'b1, 3'd2, 16'hF000, 8'h00, 4'h0);

    // R7 release bus reset, R8 lock, R9 key
    step(1'b1, 3'd3, 16'h8000, 8'h00, 4'h0);
    rd_check("R7", 3'd3);
    out_check("R7");
    step(1'b1, 3'd3, 16'hC123, 8'h00, 4'h0);
    step(1'b1, 3'd3, 16'h0000, 8'h00, 4'h0);
    rd_check("R8", 3'd3);
    out_check("R8");
    step(1'b1, 3'd3, 16'hA05F, 8'h00, 4'h0);
    rd_check("R9", 3'd3);
    step(1'b1, 3'd3, 16'h0000, 8'h00, 4'h0);
    rd_check("R7", 3'd3);
    out_check("R7");

    // R1 R2 R3 R4 R6 R7 R8 R9: random mix
    for (int n = 0; n < 400; n++) begin
      logic [2:0]  a;
      logic [15:0] d;
      logic [7:0]  e;
      logic [3:0]  x;
      a = 3'($urandom_range(0, 5));
      d = 16'($urandom);
      if (a == 3'd3 && $urandom_range(0, 3) == 0) d = 16'hA05F;
      if (a == 3'd4 && $urandom_range(0, 1) == 0) d[10] = 1'b1;
      e = ($urandom_range(0, 2) == 0) ? 8'($urandom) : 8'h00;
      x = ($urandom_range(0, 2) == 0) ? 4'($urandom) : 4'h0;
      step(1'($urandom_range(0, 3) != 0), a, d, e, x);
      rd_check("R11", 3'($urandom_range(0, 7)));
      out_check("R4");
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule